// File: doc/BRIEF.md
# Block Register Transfer Sequencer

This block runs the memory side of a multi-register load or store. One start pulse gives it a base address, a 16-bit register mask, a direction flag (load or store), an addressing mode (ascending from the base, or ending at the base) and a writeback enable. It also receives the result of the instruction's condition test. It counts the selected registers, works out the first, last and written-back addresses in advance, and then makes one 32-bit word access per selected register over a request/ready memory handshake. Registers are visited from the lowest index to the highest, and the address rises by four at each step.

For every access the sequencer shows the register index. On a store it takes that register's value from an external register file on `st_data`. On a load it returns the fetched word with a write strobe. Register 15 is the program counter: a load into it goes out on a separate program-counter port with bit 0 cleared. After the last access a one-cycle completion cycle presents the written-back base and a data-abort flag. The data-abort flag is raised when the address reached does not equal the precomputed final address.

The controller has three states. IDLE waits for `start`. IDLE→XFER is taken on start when the condition passes and the mask is non-empty. IDLE→FINISH is taken on start when the condition fails or the mask is empty. XFER holds a request. XFER→XFER is taken on an acknowledged access that is not the last. XFER→FINISH is taken on the acknowledged last access. FINISH lasts exactly one cycle and always returns FINISH→IDLE.

Top module: `blkxfer_seq`

## Requirements
- R1: With the condition passing, the number of accesses equals the number of set bits in `reg_mask`. Accesses go in ascending register index (bit i of the mask selects register i), and each access is 4 bytes above the previous one.
- R2: In ascending mode (`dec_mode`=0) the first address is the base and the last is base + 4·n − 4, where n is the count of selected registers.
- R3: In descending mode (`dec_mode`=1) the first address is base − 4·n + 4 and the last is the base.
- R4: `wb_valid` is high only in the completion cycle, and only when `wb_en` and `cond_ok` were both 1 at start. `wb_value` is then base + 4·n in ascending mode and base − 4·n in descending mode.
- R5: An acknowledged load of register 15 raises `pc_load` with `pc_value` equal to `mem_rdata` with bit 0 cleared, and does not raise `ld_we`.
- R6: An acknowledged load of registers 0 to 14 raises `ld_we` in the acknowledge cycle, with `ld_data` = `mem_rdata` and `xfer_idx` naming the destination.
- R7: During a store, `mem_we` is 1 and `mem_wdata` equals `st_data`. During a load, `mem_we` is 0.
- R8: `data_abort` is raised in the completion cycle when the address reached does not equal the precomputed final address. A correct run leaves it 0.
- R9: When `cond_ok` is 0 at start, no request is issued, `done` rises one cycle after start, and `wb_valid` stays low.
- R10: An empty mask completes one cycle after start with no request. With writeback enabled, `wb_value` equals the base.
- R11: `busy` is high from the cycle after start through the completion cycle, and low after it. A `start` pulse during a run has no effect.
- R12: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_addr` and `xfer_idx` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (sampled in IDLE) |
| base_addr | input | 32 | Base register value |
| reg_mask | input | 16 | Selected registers, bit i = register i |
| is_load | input | 1 | 1 = load, 0 = store |
| dec_mode | input | 1 | 0 = ascending from base, 1 = ending at base |
| wb_en | input | 1 | Write the updated base back |
| cond_ok | input | 1 | Condition test passed |
| st_data | input | 32 | Value of register `xfer_idx` for stores |
| mem_ready | input | 1 | Memory accepts/returns the current access |
| mem_rdata | input | 32 | Load data, valid with `mem_ready` |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Completion cycle |
| mem_req | output | 1 | Access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word address of the access |
| mem_wdata | output | 32 | Store data |
| xfer_idx | output | 4 | Register of the current access |
| ld_we | output | 1 | Write `ld_data` into register `xfer_idx` |
| ld_data | output | 32 | Loaded word |
| pc_load | output | 1 | Program counter load strobe |
| pc_value | output | 32 | New program counter, bit 0 cleared |
| wb_valid | output | 1 | Write `wb_value` into the base register |
| wb_value | output | 32 | Updated base |
| data_abort | output | 1 | Final address mismatch |

## Verification
Each result has its own due cycle. Request address, index and direction are valid from the first cycle after start, and are held until the cycle in which `mem_ready` is seen high. Load strobes and store data belong to that same acknowledge cycle. `done`, `wb_valid`, `wb_value` and `data_abort` appear one cycle after the last acknowledge, or one cycle after start when there is nothing to move. The bench drives inputs on falling edges, re-reads the combinational load outputs a nanosecond after raising `mem_ready`, and checks every cycle against a queue of expected accesses built from the mask and mode. It also counts the cycles to completion, so that an early or late `done` is caught.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_FINISH
    } xfer_state_e;
endpackage

// File: rtl/blkxfer_popcnt.sv
module blkxfer_popcnt #(
    parameter int N  = 16,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  bits_in,
    output logic [CW-1:0] count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < N; i++) begin
            count = count + CW'(bits_in[i]);
        end
    end
endmodule

// File: rtl/blkxfer_lowbit.sv
module blkxfer_lowbit #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx
);
    // lowest set bit wins; scan from the top so the last hit is the lowest
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/blkxfer_addr_plan.sv
module blkxfer_addr_plan #(
    parameter int AW         = 32,
    parameter int CW         = 5,
    parameter int WORD_BYTES = 4
) (
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] count,
    input  logic          dec_mode,
    output logic [AW-1:0] first_addr,
    output logic [AW-1:0] end_addr,
    output logic [AW-1:0] wb_addr
);
    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

    logic [AW-1:0] span;

    always_comb begin
        span = AW'(count) * STEP;
        if (dec_mode) begin
            first_addr = base - span + STEP;
            end_addr   = base;
            wb_addr    = base - span;
        end else begin
            first_addr = base;
            end_addr   = base + span - STEP;
            wb_addr    = base + span;
        end
    end
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
    import blkxfer_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int NREGS      = 16,
    parameter int WORD_BYTES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [AW-1:0]            base_addr,
    input  logic [NREGS-1:0]         reg_mask,
    input  logic                     is_load,
    input  logic                     dec_mode,
    input  logic                     wb_en,
    input  logic                     cond_ok,
    input  logic [DW-1:0]            st_data,
    input  logic                     mem_ready,
    input  logic [DW-1:0]            mem_rdata,
    output logic                     busy,
    output logic                     done,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic [AW-1:0]            mem_addr,
    output logic [DW-1:0]            mem_wdata,
    output logic [$clog2(NREGS)-1:0] xfer_idx,
    output logic                     ld_we,
    output logic [DW-1:0]            ld_data,
    output logic                     pc_load,
    output logic [DW-1:0]            pc_value,
    output logic                     wb_valid,
    output logic [AW-1:0]            wb_value,
    output logic                     data_abort
);
    localparam int              IW     = $clog2(NREGS);
    localparam int              CW     = $clog2(NREGS + 1);
    localparam logic [IW-1:0]   PC_IDX = IW'(NREGS - 1);
    localparam logic [AW-1:0]   STEP   = AW'(WORD_BYTES);

    xfer_state_e state_q, state_d;

    logic [NREGS-1:0] pend_q, pend_next;
    logic [AW-1:0]    cur_addr_q, end_q, wb_q, last_q;
    logic             ld_q, wb_go_q, moved_q;
    logic [IW-1:0]    cur_idx;
    logic [CW-1:0]    sel_count;
    logic [AW-1:0]    plan_first, plan_end, plan_wb;
    logic             hs;

    blkxfer_popcnt #(.N(NREGS), .CW(CW)) u_cnt (
        .bits_in (reg_mask),
        .count   (sel_count)
    );

    blkxfer_addr_plan #(.AW(AW), .CW(CW), .WORD_BYTES(WORD_BYTES)) u_plan (
        .base       (base_addr),
        .count      (sel_count),
        .dec_mode   (dec_mode),
        .first_addr (plan_first),
        .end_addr   (plan_end),
        .wb_addr    (plan_wb)
    );

    blkxfer_lowbit #(.N(NREGS), .IW(IW)) u_pick (
        .vec (pend_q),
        .idx (cur_idx)
    );

    assign hs        = (state_q == ST_XFER) && mem_ready;
    assign pend_next = pend_q & ~(NREGS'(1) << cur_idx);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (!cond_ok || reg_mask == '0) state_d = ST_FINISH;
                    else                            state_d = ST_XFER;
                end
            end
            ST_XFER: begin
                if (mem_ready && pend_next == '0) state_d = ST_FINISH;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transfer context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q     <= '0;
            cur_addr_q <= '0;
            end_q      <= '0;
            wb_q       <= '0;
            last_q     <= '0;
            ld_q       <= 1'b0;
            wb_go_q    <= 1'b0;
            moved_q    <= 1'b0;
        end else if (state_q == ST_IDLE && start) begin
            pend_q     <= cond_ok ? reg_mask : '0;
            cur_addr_q <= plan_first;
            end_q      <= plan_end;
            wb_q       <= plan_wb;
            last_q     <= plan_first;
            ld_q       <= is_load;
            wb_go_q    <= wb_en && cond_ok;
            moved_q    <= cond_ok && (reg_mask != '0);
        end else if (hs) begin
            pend_q     <= pend_next;
            cur_addr_q <= cur_addr_q + STEP;
            if (pend_next == '0) last_q <= cur_addr_q;
        end
    end

    // outputs
    always_comb begin
        busy       = (state_q != ST_IDLE);
        done       = (state_q == ST_FINISH);
        mem_req    = (state_q == ST_XFER);
        mem_we     = mem_req && !ld_q;
        mem_addr   = cur_addr_q;
        mem_wdata  = st_data;
        xfer_idx   = cur_idx;
        ld_we      = hs && ld_q && (cur_idx != PC_IDX);
        pc_load    = hs && ld_q && (cur_idx == PC_IDX);
        ld_data    = mem_rdata;
        pc_value   = mem_rdata & ~DW'(1);
        wb_valid   = done && wb_go_q;
        wb_value   = wb_q;
        data_abort = done && moved_q && (last_q != end_q);
    end

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(xfer_idx));

    assert_step_up_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ready |=> !mem_req ||
            (mem_addr == $past(mem_addr) + STEP && xfer_idx > $past(xfer_idx)));

    assert_wb_in_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> done);

    assert_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_skip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && !cond_ok |=> done && !mem_req && !wb_valid);

    assert_pc_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> !ld_we && mem_req);
endmodule

// File: tb/blkxfer_seq_test.sv
module blkxfer_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] base_addr = '0;
    logic [15:0] reg_mask = '0;
    logic        is_load = 1'b0, dec_mode = 1'b0, wb_en = 1'b0, cond_ok = 1'b0;
    logic [31:0] st_data;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        busy, done, mem_req, mem_we, ld_we, pc_load, wb_valid, data_abort;
    logic [31:0] mem_addr, mem_wdata, ld_data, pc_value, wb_value;
    logic [3:0]  xfer_idx;

    logic [31:0] rf [16];
    logic [31:0] mem [logic [31:0]];
    int vecs = 0;
    int errs = 0;
    bit finished = 0;

    assign st_data = rf[xfer_idx];

    always #10 clk = ~clk;

    blkxfer_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .reg_mask(reg_mask), .is_load(is_load), .dec_mode(dec_mode),
        .wb_en(wb_en), .cond_ok(cond_ok), .st_data(st_data),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .xfer_idx(xfer_idx), .ld_we(ld_we),
        .ld_data(ld_data), .pc_load(pc_load), .pc_value(pc_value),
        .wb_valid(wb_valid), .wb_value(wb_value), .data_abort(data_abort)
    );

    function automatic logic [31:0] rd_mem(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return a ^ 32'h5A5A_0F0F;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [31:0] base, input logic [15:0] mask,
                          input bit ld, input bit dec, input bit wb,
                          input bit cond, input bit poke);
        int          n;
        logic [31:0] a;
        logic [31:0] q_addr[$];
        int          q_idx[$];
        logic [31:0] exp_wb;
        int          cyc;
        bit          poked;
        n = $countones(mask);
        a = dec ? base - 32'(4 * n) + 32'd4 : base;
        exp_wb = dec ? base - 32'(4 * n) : base + 32'(4 * n);
        if (cond) begin
            for (int i = 0; i < 16; i++) begin
                if (mask[i]) begin
                    q_addr.push_back(a);
                    q_idx.push_back(i);
                    a = a + 32'd4;
                end
            end
        end
        for (int i = 0; i < 16; i++) rf[i] = $urandom;
        @(negedge clk);
        base_addr = base; reg_mask = mask; is_load = ld; dec_mode = dec;
        wb_en = wb; cond_ok = cond; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        base_addr = $urandom; reg_mask = 16'hFFFF; // must not matter after start
        cyc = 0;
        poked = 0;
        while (!done && cyc < 200) begin
            chk(busy === 1'b1, "R11 busy during run", 32'(busy), 32'd1);
            if (mem_req) begin
                if (q_addr.size() == 0) begin
                    chk(0, "R1 extra access", mem_addr, 32'hFFFF_FFFF);
                end else begin
                    chk(mem_addr === q_addr[0], dec ? "R3 address" : "R2 address",
                        mem_addr, q_addr[0]);
                    chk(32'(xfer_idx) === 32'(q_idx[0]), "R1 register order",
                        32'(xfer_idx), 32'(q_idx[0]));
                    chk(mem_we === !ld, "R7 direction", 32'(mem_we), 32'(!ld));
                    if (poke && !poked) begin
                        start = 1'b1;
                        poked = 1;
                    end
                    mem_ready = ($urandom % 3) != 0;
                    if (mem_ready) begin
                        if (ld) begin
                            mem_rdata = rd_mem(mem_addr);
                            #1;
                            if (q_idx[0] == 15) begin
                                chk(pc_load === 1'b1 && ld_we === 1'b0,
                                    "R5 pc strobe", 32'(pc_load), 32'd1);
                                chk(pc_value === (mem_rdata & ~32'd1),
                                    "R5 pc value", pc_value, mem_rdata & ~32'd1);
                            end else begin
                                chk(ld_we === 1'b1 && pc_load === 1'b0,
                                    "R6 load strobe", 32'(ld_we), 32'd1);
                                chk(ld_data === mem_rdata, "R6 load data",
                                    ld_data, mem_rdata);
                            end
                        end else begin
                            #1;
                            chk(mem_wdata === rf[q_idx[0]], "R7 store data",
                                mem_wdata, rf[q_idx[0]]);
                            mem[mem_addr] = mem_wdata;
                        end
                        void'(q_addr.pop_front());
                        void'(q_idx.pop_front());
                    end
                end
            end
            @(negedge clk);
            mem_ready = 1'b0;
            start = 1'b0;
            cyc++;
        end
        chk(done === 1'b1, "R11 completion reached", 32'(done), 32'd1);
        chk(q_addr.size() == 0, "R1 access count", 32'(q_addr.size()), 32'd0);
        chk(mem_req === 1'b0, "R1 no request at completion", 32'(mem_req), 32'd0);
        if (!cond)
            chk(cyc == 0, "R9 done one cycle after start", 32'(cyc), 32'd0);
        else if (n == 0)
            chk(cyc == 0, "R10 empty list done one cycle after start", 32'(cyc), 32'd0);
        chk(wb_valid === (wb && cond), cond ? "R4 writeback strobe" : "R9 no writeback",
            32'(wb_valid), 32'(wb && cond));
        if (wb && cond)
            chk(wb_value === exp_wb, n == 0 ? "R10 base unchanged" : "R4 writeback value",
                wb_value, exp_wb);
        chk(data_abort === 1'b0, "R8 no abort", 32'(data_abort), 32'd0);
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R11 idle after completion",
            32'(busy), 32'd0);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            errs++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && mem_req === 1'b0,
            "R11 reset state", 32'(busy), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && mem_req === 1'b0 && wb_valid === 1'b0,
            "R11 idle after reset", 32'(mem_req), 32'd0);
        // directed cases
        run_op(32'h0000_1000, 16'hFFFF, 1, 0, 1, 1, 0); // full load incl. pc, R2 R5
        run_op(32'h0000_2000, 16'h8421, 0, 1, 1, 1, 1); // store, descending, R3 R7
        run_op(32'h0000_3000, 16'h0000, 1, 0, 1, 1, 0); // R10
        run_op(32'h0000_3000, 16'h0000, 0, 1, 1, 1, 0); // R10 descending
        run_op(32'h0000_4000, 16'h00F0, 1, 0, 1, 0, 0); // R9
        run_op(32'h0000_5000, 16'h8000, 1, 1, 0, 1, 0); // single pc load, R5
        run_op(32'h0000_6000, 16'h0001, 0, 0, 1, 1, 1); // single store
        run_op(32'h0000_0004, 16'h000F, 1, 1, 1, 1, 0); // descending wraps below 0
        // random operations in both modes
        for (int k = 0; k < 80; k++) begin
            run_op({$urandom_range(0, 32'h3FFF), 2'b00} + 32'h1_0000,
                   16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                   ($urandom % 6) != 0, ($urandom % 4) == 0);
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule